// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block keeps the status flags of an asynchronous serial port that can carry a multiprocessor bit in each frame. It holds four bits: a parity error flag, a transmit-complete flag, the multiprocessor bit taken from the last accepted frame, and the multiprocessor bit to send with the next frame. The receiver and transmitter cores send it single-cycle event strobes. The enable controls, the state of the transmit-data-empty flag and a CPU read/write port decide when each bit sets, holds or clears.

The parity error flag follows a three-state machine. In `PE_CLEAR` the flag is 0. An accepted parity error takes it to `PE_FLAGGED`, where the flag is 1 and no clear is possible yet. A CPU read without a write in the same cycle takes it on to `PE_ARMED`. From `PE_ARMED`, a write with 0 in the flag position goes back to `PE_CLEAR`. A write with 1 there goes back to `PE_FLAGGED`, and so does a new parity error, which wins over a clear in the same cycle. While the flag is 1, reception is blocked: good frames do not raise the receive-full pulse and do not update the received multiprocessor bit. In clocked synchronous mode, transmission is blocked as well.

The transmit-complete flag follows a two-state machine. `TE_DONE` (flag 1) moves to `TE_PENDING` when software clears the data-empty flag or when a DMA transfer writes the transmit data register. This happens only while transmit is enabled and no completing event occurs in the same cycle. `TE_PENDING` returns to `TE_DONE` when transmit is disabled, or when the last bit of a character is shifted out while the data-empty flag is 1. Both machines leave reset in the state that gives the flag its reset value.

Top module: `serial_flag_reg`

## Requirements
- R1: After reset, the read word is 0b0100: bit 3 = parity error 0, bit 2 = transmit complete 1, bit 1 = received MP bit 0, bit 0 = transmit MP bit 0. Bits above 3 always read 0.
- R2: A frame-done strobe with parity_bad while rx_en is 1 sets the parity error flag on the next cycle, and rx_full_set stays 0 for that frame.
- R3: While the parity error flag is 1, rx_block is 1 and a good frame neither raises rx_full_set nor changes the received MP bit. tx_block equals the flag ANDed with sync_mode.
- R4: The parity error flag clears only on a write with bit 3 = 0 that comes after a read returned it as 1, with no other write in between. Writing 1 to bit 3, or writing 0 without a prior read, leaves the flag at 1.
- R5: If a parity error is accepted in the same cycle as an armed clearing write, the flag stays 1 and the arm is dropped, so a following write of 0 with no new read does not clear it.
- R6: While rx_en is 0, frame strobes change neither the parity error flag nor the received MP bit, and rx_full_set stays 0.
- R7: The cycle after tx_en is 0, the transmit-complete flag is 1, whatever the clear strobes do.
- R8: With tx_en = 1, a last-bit strobe sets the transmit-complete flag on the next cycle if tx_empty is 1, and leaves a cleared flag at 0 if tx_empty is 0.
- R9: With tx_en = 1, a tdre_sw_clr or dma_tdr_wr strobe clears the transmit-complete flag on the next cycle. A set in the same cycle wins.
- R10: An accepted frame (rx_en = 1, flag 0) loads rx_mpb_in into the received MP bit. CPU writes to bits 2 and 1 have no effect.
- R11: A CPU write loads bit 0 of the write data into the transmit MP bit, which drives tx_mpb_out and reads back in bit 0.
- R12: rx_full_set is 1 in the same cycle as a frame-done strobe when rx_en is 1, parity_bad is 0 and the parity error flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable |
| tx_en | input | 1 | Transmit enable |
| sync_mode | input | 1 | 1 = clocked synchronous mode |
| rx_frame_done | input | 1 | Receiver strobe: a frame has ended |
| rx_parity_bad | input | 1 | Qualifies rx_frame_done: the frame had a parity error |
| rx_mpb_in | input | 1 | MP bit of the ending frame |
| tx_last_bit | input | 1 | Transmitter strobe: last bit of a character shifted out |
| tx_empty | input | 1 | Current state of the transmit-data-empty flag |
| tdre_sw_clr | input | 1 | Strobe: software cleared the data-empty flag |
| dma_tdr_wr | input | 1 | Strobe: a DMA transfer started by the transmit interrupt wrote the transmit data register |
| reg_rd | input | 1 | CPU read of this register |
| reg_wr | input | 1 | CPU write of this register |
| reg_wdata | input | DATA_W | CPU write data |
| reg_rdata | output | DATA_W | Read word: {0.., parity error, transmit complete, received MP, transmit MP} |
| rx_full_set | output | 1 | Allows the receive-full flag to set for the ending frame |
| rx_block | output | 1 | Reception blocked |
| tx_block | output | 1 | Transmission blocked (synchronous mode) |
| tx_mpb_out | output | 1 | MP bit for the next transmitted frame |
| flag_parity | output | 1 | Parity error flag |
| flag_tx_end | output | 1 | Transmit-complete flag |
| flag_rx_mpb | output | 1 | Received MP bit |

## Verification
The assertions rely on every qualifier being valid in the cycle its strobe is high: rx_parity_bad and rx_mpb_in alongside rx_frame_done, and tx_empty alongside tx_last_bit. The strobes count only in that one cycle. The bench drives each strobe high for exactly one cycle with its qualifiers already set. Inputs change one clock phase after the edge, and the CPU port never reads and writes in the same cycle.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    localparam int POS_PER  = 3;
    localparam int POS_TEND = 2;
    localparam int POS_RMPB = 1;
    localparam int POS_TMPB = 0;
    localparam int NUM_BITS = 4;

    typedef enum logic [1:0] {
        PE_CLEAR   = 2'd0,
        PE_FLAGGED = 2'd1,
        PE_ARMED   = 2'd2
    } perr_state_e;

    typedef enum logic {
        TE_PENDING = 1'b0,
        TE_DONE    = 1'b1
    } tend_state_e;
endpackage

// File: rtl/sfr_perr_fsm.sv
module sfr_perr_fsm
    import sfr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic cpu_rd,
    input  logic cpu_wr,
    input  logic wr_bit,
    output logic flag
);
    perr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PE_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PE_CLEAR: begin
                if (set_evt) state_d = PE_FLAGGED;
            end
            PE_FLAGGED: begin
                if (!set_evt && cpu_rd && !cpu_wr) state_d = PE_ARMED;
            end
            PE_ARMED: begin
                if (set_evt)              state_d = PE_FLAGGED;
                else if (cpu_wr && !wr_bit) state_d = PE_CLEAR;
                else if (cpu_wr)          state_d = PE_FLAGGED;
            end
            default: state_d = PE_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state_q != PE_CLEAR);
    end
endmodule

// File: rtl/sfr_tend_fsm.sv
module sfr_tend_fsm
    import sfr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic last_bit,
    input  logic empty,
    input  logic clr_evt,
    output logic flag
);
    tend_state_e state_q, state_d;
    logic        done_evt;

    assign done_evt = last_bit && empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TE_DONE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TE_DONE: begin
                if (tx_en && clr_evt && !done_evt) state_d = TE_PENDING;
            end
            TE_PENDING: begin
                if (!tx_en || done_evt) state_d = TE_DONE;
            end
            default: state_d = TE_DONE;
        endcase
    end

    always_comb begin
        flag = (state_q == TE_DONE);
    end
endmodule

// File: rtl/sfr_mpb_regs.sv
module sfr_mpb_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_accept,
    input  logic rx_bit,
    input  logic cpu_wr,
    input  logic wr_bit,
    output logic rx_mpb,
    output logic tx_mpb
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_mpb <= 1'b0;
            tx_mpb <= 1'b0;
        end else begin
            if (rx_accept) rx_mpb <= rx_bit;
            if (cpu_wr)    tx_mpb <= wr_bit;
        end
    end
endmodule

// File: rtl/serial_flag_reg.sv
module serial_flag_reg
    import sfr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              tx_en,
    input  logic              sync_mode,
    input  logic              rx_frame_done,
    input  logic              rx_parity_bad,
    input  logic              rx_mpb_in,
    input  logic              tx_last_bit,
    input  logic              tx_empty,
    input  logic              tdre_sw_clr,
    input  logic              dma_tdr_wr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              rx_full_set,
    output logic              rx_block,
    output logic              tx_block,
    output logic              tx_mpb_out,
    output logic              flag_parity,
    output logic              flag_tx_end,
    output logic              flag_rx_mpb
);
    logic perr_evt;
    logic frame_ok;
    logic unused_wbits;

    assign unused_wbits = ^reg_wdata;
    assign perr_evt     = rx_en && rx_frame_done && rx_parity_bad;
    assign frame_ok     = rx_en && rx_frame_done && !flag_parity;

    sfr_perr_fsm u_perr (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (perr_evt),
        .cpu_rd  (reg_rd),
        .cpu_wr  (reg_wr),
        .wr_bit  (reg_wdata[POS_PER]),
        .flag    (flag_parity)
    );

    sfr_tend_fsm u_tend (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .last_bit (tx_last_bit),
        .empty    (tx_empty),
        .clr_evt  (tdre_sw_clr || dma_tdr_wr),
        .flag     (flag_tx_end)
    );

    sfr_mpb_regs u_mpb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_accept (frame_ok),
        .rx_bit    (rx_mpb_in),
        .cpu_wr    (reg_wr),
        .wr_bit    (reg_wdata[POS_TMPB]),
        .rx_mpb    (flag_rx_mpb),
        .tx_mpb    (tx_mpb_out)
    );

    always_comb begin
        reg_rdata           = '0;
        reg_rdata[POS_PER]  = flag_parity;
        reg_rdata[POS_TEND] = flag_tx_end;
        reg_rdata[POS_RMPB] = flag_rx_mpb;
        reg_rdata[POS_TMPB] = tx_mpb_out;
    end

    assign rx_full_set = frame_ok && !rx_parity_bad;
    assign rx_block    = flag_parity;
    assign tx_block    = flag_parity && sync_mode;
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              tx_en,
    input logic              rx_frame_done,
    input logic              rx_parity_bad,
    input logic              tx_last_bit,
    input logic              tx_empty,
    input logic              tdre_sw_clr,
    input logic              dma_tdr_wr,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              rx_full_set,
    input logic              tx_mpb_out,
    input logic              flag_parity,
    input logic              flag_tx_end,
    input logic              flag_rx_mpb
);
    p_perr_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rx_frame_done && rx_parity_bad) |=> flag_parity);

    p_no_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_parity_bad |-> !rx_full_set);

    p_blocked_mpb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_parity && rx_frame_done) |=> $stable(flag_rx_mpb));

    p_no_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_parity && !(reg_wr && !reg_wdata[3])) |=> flag_parity);

    p_rx_off_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !reg_wr) |=> ($stable(flag_parity) && $stable(flag_rx_mpb)));

    p_tx_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> flag_tx_end);

    p_tend_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_last_bit && tx_empty) |=> flag_tx_end);

    p_tend_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && (tdre_sw_clr || dma_tdr_wr) && !(tx_last_bit && tx_empty)) |=> !flag_tx_end);

    p_tmpb_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (tx_mpb_out == $past(reg_wdata[0])));
endmodule

bind serial_flag_reg sfr_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_serial_flag_reg.sv
`timescale 1ns/1ps
module sim_serial_flag_reg;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en, tx_en, sync_mode, rx_frame_done, rx_parity_bad, rx_mpb_in;
    logic tx_last_bit, tx_empty, tdre_sw_clr, dma_tdr_wr, reg_rd, reg_wr;
    logic [DW-1:0] reg_wdata, reg_rdata;
    logic rx_full_set, rx_block, tx_block, tx_mpb_out;
    logic flag_parity, flag_tx_end, flag_rx_mpb;

    int n_total = 0;
    int n_pass  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    serial_flag_reg #(.DATA_W(DW)) u0 (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
        n_total++;
        if (got === exp) n_pass++;
        else $display("FAIL %s: got %0h expected %0h", req, got, exp);
    endtask

    function automatic logic [DW-1:0] word(logic per, logic te, logic rm, logic tm);
        word = '0;
        word[3] = per; word[2] = te; word[1] = rm; word[0] = tm;
    endfunction

    task automatic cpu_read();
        reg_rd = 1'b1; tick(); reg_rd = 1'b0;
    endtask

    task automatic cpu_write(logic [DW-1:0] d);
        reg_wr = 1'b1; reg_wdata = d; tick(); reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic frame(logic bad, logic mpb, logic exp_full, string req);
        rx_frame_done = 1'b1; rx_parity_bad = bad; rx_mpb_in = mpb;
        #1;
        check(req, rx_full_set, exp_full);
        tick();
        rx_frame_done = 1'b0; rx_parity_bad = 1'b0; rx_mpb_in = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset word", reg_rdata, word(0, 1, 0, 0));
        check("R1 reset tx_mpb", tx_mpb_out, 0);
    endtask

    task automatic t_tx_mpb();
        cpu_write(8'hFF);
        check("R11 tmpb set / R10 bits2,1 ignored", reg_rdata, word(0, 1, 0, 1));
        check("R11 tx_mpb_out", tx_mpb_out, 1);
        cpu_write(8'h00);
        check("R10 write 0 ignored on tend", reg_rdata, word(0, 1, 0, 0));
    endtask

    task automatic t_good_frame();
        frame(0, 1, 1, "R12 full pulse");
        check("R10 rmpb captured", flag_rx_mpb, 1);
        check("R12 no parity flag", flag_parity, 0);
    endtask

    task automatic t_parity_frame();
        frame(1, 0, 0, "R2 no full on parity error");
        check("R2 parity flag set", reg_rdata, word(1, 1, 0, 0));
        check("R3 rx_block", rx_block, 1);
        check("R3 tx_block async", tx_block, 0);
        sync_mode = 1'b1; #1;
        check("R3 tx_block sync", tx_block, 1);
        sync_mode = 1'b0;
        frame(0, 1, 0, "R3 blocked frame no full");
        check("R3 rmpb held", flag_rx_mpb, 0);
    endtask

    task automatic t_clear_rule();
        cpu_write(8'h00);
        check("R4 write0 without read", flag_parity, 1);
        cpu_read();
        cpu_write(8'h08);
        check("R4 write1 no effect", flag_parity, 1);
        cpu_write(8'h00);
        check("R4 arm dropped by write", flag_parity, 1);
        cpu_read();
        cpu_write(8'h00);
        check("R4 read then write0 clears", flag_parity, 0);
    endtask

    task automatic t_set_wins();
        frame(1, 0, 0, "R5 setup no full");
        cpu_read();
        reg_wr = 1'b1; reg_wdata = '0;
        rx_frame_done = 1'b1; rx_parity_bad = 1'b1;
        tick();
        reg_wr = 1'b0; rx_frame_done = 1'b0; rx_parity_bad = 1'b0;
        check("R5 set wins", flag_parity, 1);
        cpu_write(8'h00);
        check("R5 arm dropped", flag_parity, 1);
        cpu_read();
        cpu_write(8'h00);
        check("R5 cleared after rearm", flag_parity, 0);
    endtask

    task automatic t_rx_disabled();
        rx_en = 1'b0;
        frame(1, 1, 0, "R6 no full while disabled");
        check("R6 per and rmpb held", reg_rdata, word(0, 1, 0, 0));
        rx_en = 1'b1;
        frame(1, 0, 0, "R6 setup");
        rx_en = 1'b0;
        tick(); tick();
        check("R6 per kept while disabled", flag_parity, 1);
        rx_en = 1'b1;
        cpu_read();
        cpu_write(8'h00);
        check("R6 cleared after enable", flag_parity, 0);
    endtask

    task automatic t_tend();
        tdre_sw_clr = 1'b1; tick(); tdre_sw_clr = 1'b0;
        check("R9 clear by tdre", flag_tx_end, 0);
        tx_last_bit = 1'b1; tx_empty = 1'b0; tick(); tx_last_bit = 1'b0;
        check("R8 no set when not empty", flag_tx_end, 0);
        tx_last_bit = 1'b1; tx_empty = 1'b1; tick(); tx_last_bit = 1'b0; tx_empty = 1'b0;
        check("R8 set on last bit", flag_tx_end, 1);
        dma_tdr_wr = 1'b1; tick(); dma_tdr_wr = 1'b0;
        check("R9 clear by dma", flag_tx_end, 0);
        tdre_sw_clr = 1'b1; tick(); tdre_sw_clr = 1'b0;
        tx_last_bit = 1'b1; tx_empty = 1'b1; dma_tdr_wr = 1'b1; tick();
        tx_last_bit = 1'b0; tx_empty = 1'b0; dma_tdr_wr = 1'b0;
        check("R9 set wins over clear", flag_tx_end, 1);
        dma_tdr_wr = 1'b1; tick(); dma_tdr_wr = 1'b0;
        tx_en = 1'b0; tdre_sw_clr = 1'b1; tick(); tdre_sw_clr = 1'b0;
        check("R7 tx disabled forces 1", flag_tx_end, 1);
        tx_en = 1'b1;
    endtask

    initial begin
        rx_en = 1; tx_en = 1; sync_mode = 0; rx_frame_done = 0; rx_parity_bad = 0;
        rx_mpb_in = 0; tx_last_bit = 0; tx_empty = 0; tdre_sw_clr = 0; dma_tdr_wr = 0;
        reg_rd = 0; reg_wr = 0; reg_wdata = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_tx_mpb();
        t_good_frame();
        frame(0, 0, 1, "R12 second good frame");
        check("R10 rmpb recaptured", flag_rx_mpb, 0);
        t_parity_frame();
        t_clear_rule();
        t_set_wins();
        t_rx_disabled();
        t_tend();
        done = 1;
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_pass, n_total);
            $finish;
        end
    end
endmodule